// File: doc/BRIEF.md
# Execute-in-place flash fetch sequencer

This block runs one read transaction against a serial flash for each fetch request it accepts. A request carries a 32-bit byte address and a byte count. The block asserts select, then walks through up to four phases: the read command, the flash address, a mode/dummy phase and a data phase. The command, address and data phases each pick their own number of I/O lines (one, two or four). The mode/dummy phase uses the address-phase line count. During that phase a 16-bit pattern is sent with a per-bit output-enable mask, so any bit can be left tri-stated.

An external clock and select generator supplies one strobe per serial clock period. The block moves every bit group on those strobes. On each strobe it presents the next bit group on the SDIO outputs and samples the SDIO inputs. Received bits are packed most significant first into bytes, and each byte leaves on a byte-wide output with a one-cycle valid pulse. A count of serial clocks measured from select assertion can be discarded before any data is taken. A command-once mode sends the read command only on the first transaction, and later fetches start directly with the address.

Configuration inputs are expected to stay stable while a transaction is in flight.

Top module: `xip_fetch_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), sel, busy, rd_vld and cfg_err are 0 and sd_oe is 0.
- R2: A request (req high while busy is low) is accepted at a clock edge. From the next cycle busy and sel are 1. req is ignored while busy is 1.
- R3: The command phase sends the 8-bit cfg_cmd most significant bit first, one group per strobe, on the lines chosen by cfg_cmd_w. Code 0 uses sd_out[0], code 1 uses sd_out[1:0] and code 2 uses sd_out[3:0], and the higher-numbered line carries the more significant bit. The lines in use are output-enabled and all other lines are disabled.
- R4: The address phase sends req_addr[23:0], or all 32 bits when cfg_addr4 is 1, most significant bit first. It uses the cfg_addr_w line count with the same line mapping as R3.
- R5: The mode phase lasts cfg_mode_clks strobes with the cfg_addr_w line count. Each group takes the next bits, most significant first, of cfg_mode_data as data and of cfg_mode_oe as per-line enable. Once all 16 bits are used the lines are disabled. A count of 0 skips the phase.
- R6: In the data phase sd_oe is 0. Each capturing strobe samples sd_in[1] for code 0, sd_in[1:0] for code 1 or sd_in[3:0] for code 2 of cfg_data_w, and earlier bits are more significant. rd_vld is high for exactly one cycle, the cycle after the strobe that completes a byte, with that byte on rd_byte.
- R7: Strobes are numbered from 0 from the first strobe after select asserts. A data-phase strobe whose number is below the skip count captures nothing. The skip count is cfg_skip_cmd when the command was sent and cfg_skip_nocmd when it was not.
- R8: A transaction delivers req_len_m1 + 1 bytes. sel and busy fall in the same cycle that rd_vld shows the last byte.
- R9: While cfg_cmd_once is 1, only the first transaction sends the command, and later ones begin with the address phase. Driving cfg_cmd_once to 0 makes the next transaction send the command again.
- R10: A width code of 3 in cfg_cmd_w, cfg_addr_w or cfg_data_w at request acceptance sets cfg_err, and that phase runs as single-line. cfg_err stays 1 until reset.
- R11: While idle, sclk_stb has no effect: busy, sel, sd_oe and rd_vld stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Fetch request |
| req_addr | input | 32 | Flash byte address of the fetch |
| req_len_m1 | input | LEN_W | Byte count minus one |
| busy | output | 1 | Transaction in progress |
| cfg_cmd | input | 8 | Read command value |
| cfg_cmd_w | input | 2 | Command line-count code |
| cfg_addr_w | input | 2 | Address and mode line-count code |
| cfg_data_w | input | 2 | Data line-count code |
| cfg_addr4 | input | 1 | 1 selects 4-byte address, 0 selects 3-byte |
| cfg_mode_clks | input | MCLK_W | Mode/dummy phase length in serial clocks |
| cfg_mode_data | input | MODE_W | Mode data pattern |
| cfg_mode_oe | input | MODE_W | Per-bit output enable for the mode pattern |
| cfg_cmd_once | input | 1 | Send the command only on the first transaction |
| cfg_skip_cmd | input | SKIP_W | Skipped serial clocks when the command is sent |
| cfg_skip_nocmd | input | SKIP_W | Skipped serial clocks when no command is sent |
| cfg_err | output | 1 | Sticky invalid width-code flag |
| sclk_stb | input | 1 | One pulse per serial clock period |
| sel | output | 1 | Flash select request, active high |
| sd_out | output | 4 | SDIO output data |
| sd_oe | output | 4 | SDIO output enables |
| sd_in | input | 4 | SDIO input data |
| rd_byte | output | 8 | Received byte |
| rd_vld | output | 1 | rd_byte valid for one cycle |

## Verification
The bench sets LEN_W to 5, so random fetches reach the largest byte count of 32. MCLK_W and SKIP_W keep their defaults, so the whole range of mode clocks (0 to 15) and skip counts (0 to 63) is drawn. With these values the skip window can fall in any phase, or run into the data phase by any number of strobes. Directed runs cover the command-once sequence, both address lengths, and a width code of 3 followed by reset.

// File: rtl/xip_pkg.sv
// Shared phase type and line-count helpers for the flash fetch sequencer.
// Assumes width codes 0/1/2 mean 1/2/4 lines; code 3 falls back to one line.
package xip_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD  = 3'd1,
        PH_ADDR = 3'd2,
        PH_MODE = 3'd3,
        PH_DATA = 3'd4
    } xip_phase_e;

    localparam int CMD_BITS = 8;
    localparam int SH_W     = 32;

    // Log2 of the line count selected by a width code
    function automatic logic [1:0] lane_log2(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/xip_tx_shifter.sv
// Transmit shifter: holds the data and output-enable patterns of the current
// outgoing phase and presents the top bit group on the SDIO lines.
// Assumes ld and shift never coincide; lg is the current phase line count.
module xip_tx_shifter
    import xip_pkg::*;
#(
    parameter int MODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  xip_phase_e        ld_phase,
    input  logic              shift,
    input  logic [1:0]        lg,
    input  logic              drive_en,
    input  logic [7:0]        cmd,
    input  logic [31:0]       addr,
    input  logic              addr4,
    input  logic [MODE_W-1:0] mode_data,
    input  logic [MODE_W-1:0] mode_oe,
    output logic [3:0]        sd_out,
    output logic [3:0]        sd_oe
);
    localparam int PAD_W = SH_W - MODE_W;

    logic [SH_W-1:0] dsh;
    logic [SH_W-1:0] osh;
    logic [2:0]      lanes;
    logic [3:0]      raw_d;
    logic [3:0]      raw_o;

    assign lanes = 3'd1 << lg;

    // Load a phase pattern or advance by one bit group per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsh <= '0;
            osh <= '0;
        end else if (ld) begin
            case (ld_phase)
                PH_CMD: begin
                    dsh <= {cmd, {(SH_W-CMD_BITS){1'b0}}};
                    osh <= '1;
                end
                PH_ADDR: begin
                    dsh <= addr4 ? addr : {addr[23:0], 8'h00};
                    osh <= '1;
                end
                PH_MODE: begin
                    dsh <= {mode_data, {PAD_W{1'b0}}};
                    osh <= {mode_oe, {PAD_W{1'b0}}};
                end
                default: begin
                    dsh <= '0;
                    osh <= '0;
                end
            endcase
        end else if (shift) begin
            dsh <= dsh << lanes;
            osh <= osh << lanes;
        end
    end

    // Map the top bit group onto the lines, higher line = more significant
    always_comb begin
        raw_d = '0;
        raw_o = '0;
        if (drive_en) begin
            case (lg)
                2'd0: begin
                    raw_d[0] = dsh[SH_W-1];
                    raw_o[0] = osh[SH_W-1];
                end
                2'd1: begin
                    raw_d[1:0] = dsh[SH_W-1 -: 2];
                    raw_o[1:0] = osh[SH_W-1 -: 2];
                end
                default: begin
                    raw_d = dsh[SH_W-1 -: 4];
                    raw_o = osh[SH_W-1 -: 4];
                end
            endcase
        end
    end

    assign sd_oe  = raw_o;
    assign sd_out = raw_d & raw_o;
endmodule

// File: rtl/xip_rx_assembler.sv
// Receive assembler: packs sampled line groups into bytes, most significant
// first, and emits each completed byte with a one-cycle valid.
// Assumes cap is asserted only on capturing data-phase strobes.
module xip_rx_assembler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cap,
    input  logic [1:0] lg,
    input  logic [3:0] sd_in,
    output logic       byte_done,
    output logic [7:0] rd_byte,
    output logic       rd_vld
);
    logic [7:0] acc;
    logic [3:0] cnt;
    logic [2:0] lanes;
    logic [3:0] grp;
    logic [7:0] nxt_acc;
    logic [3:0] nxt_cnt;

    assign lanes = 3'd1 << lg;

    // Select the sampled lines: one line reads sd_in[1]
    always_comb begin
        case (lg)
            2'd0:    grp = {3'b000, sd_in[1]};
            2'd1:    grp = {2'b00, sd_in[1:0]};
            default: grp = sd_in;
        endcase
    end

    assign nxt_acc   = (acc << lanes) | {4'h0, grp};
    assign nxt_cnt   = cnt + {1'b0, lanes};
    assign byte_done = cap && (nxt_cnt == 4'd8);

    // Accumulate bits and publish a byte when eight have arrived
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            cnt     <= '0;
            rd_byte <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= byte_done;
            if (start) begin
                acc <= '0;
                cnt <= '0;
            end else if (byte_done) begin
                rd_byte <= nxt_acc;
                acc     <= '0;
                cnt     <= '0;
            end else if (cap) begin
                acc <= nxt_acc;
                cnt <= nxt_cnt;
            end
        end
    end

    // R6
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> !rd_vld);
endmodule

// File: rtl/xip_seq_ctrl.sv
// Phase controller: accepts a fetch, steps command/address/mode/data phases on
// serial clock strobes, applies the skip window and the command-once rule.
// Assumes configuration inputs are stable while busy.
module xip_seq_ctrl
    import xip_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int SKIP_W = 6,
    parameter int MCLK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              sclk_stb,
    input  logic [1:0]        cfg_cmd_w,
    input  logic [1:0]        cfg_addr_w,
    input  logic [1:0]        cfg_data_w,
    input  logic              cfg_addr4,
    input  logic [MCLK_W-1:0] cfg_mode_clks,
    input  logic              cfg_cmd_once,
    input  logic [SKIP_W-1:0] cfg_skip_cmd,
    input  logic [SKIP_W-1:0] cfg_skip_nocmd,
    input  logic              byte_done,
    output logic              busy,
    output logic              sel,
    output logic              ld,
    output xip_phase_e        ld_phase,
    output logic              shift,
    output logic [1:0]        lg,
    output logic              drive_en,
    output logic              cap,
    output logic              rx_start,
    output logic              cfg_err
);
    localparam int SLOT_W = (MCLK_W > 6) ? MCLK_W : 6;

    xip_phase_e        ph, nxt_ph;
    logic [SLOT_W-1:0] slot, nxt_slot;
    logic [SKIP_W:0]   sidx;
    logic [SKIP_W-1:0] skip_q;
    logic [LEN_W-1:0]  left;
    logic              cmd_done;
    logic              err_q;
    logic              stb, last, accept, send_cmd, bad_code;
    logic [1:0]        lg_cmd, lg_addr, lg_data;
    logic [5:0]        abits;

    // Groups in a phase of nbits at 2**l lines, minus one
    function automatic logic [SLOT_W-1:0] slots_m1(input logic [5:0] nbits,
                                                   input logic [1:0] l);
        return SLOT_W'(nbits >> l) - SLOT_W'(1);
    endfunction

    assign lg_cmd   = lane_log2(cfg_cmd_w);
    assign lg_addr  = lane_log2(cfg_addr_w);
    assign lg_data  = lane_log2(cfg_data_w);
    assign abits    = cfg_addr4 ? 6'd32 : 6'd24;
    assign sel      = (ph != PH_IDLE);
    assign busy     = sel;
    assign stb      = sclk_stb && sel;
    assign last     = (slot == '0);
    assign accept   = (ph == PH_IDLE) && req;
    assign send_cmd = !(cfg_cmd_once && cmd_done);
    assign drive_en = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_MODE);
    assign shift    = stb && drive_en && !last;
    assign cap      = stb && (ph == PH_DATA) && ({1'b0, skip_q} <= sidx);
    assign rx_start = accept;
    assign cfg_err  = err_q;
    assign bad_code = (cfg_cmd_w == 2'd3) || (cfg_addr_w == 2'd3) || (cfg_data_w == 2'd3);

    // Line count of the phase currently on the bus
    always_comb begin
        case (ph)
            PH_CMD:          lg = lg_cmd;
            PH_ADDR, PH_MODE: lg = lg_addr;
            PH_DATA:         lg = lg_data;
            default:         lg = 2'd0;
        endcase
    end

    // Next phase, next group count and shifter load request
    always_comb begin
        nxt_ph   = ph;
        nxt_slot = slot;
        ld       = 1'b0;
        ld_phase = PH_IDLE;
        case (ph)
            PH_IDLE: if (req) begin
                ld = 1'b1;
                if (send_cmd) begin
                    nxt_ph   = PH_CMD;
                    nxt_slot = slots_m1(6'(CMD_BITS), lg_cmd);
                end else begin
                    nxt_ph   = PH_ADDR;
                    nxt_slot = slots_m1(abits, lg_addr);
                end
                ld_phase = nxt_ph;
            end
            PH_CMD: if (stb) begin
                if (last) begin
                    nxt_ph   = PH_ADDR;
                    nxt_slot = slots_m1(abits, lg_addr);
                    ld       = 1'b1;
                    ld_phase = PH_ADDR;
                end else begin
                    nxt_slot = slot - 1'b1;
                end
            end
            PH_ADDR: if (stb) begin
                if (last) begin
                    if (cfg_mode_clks != '0) begin
                        nxt_ph   = PH_MODE;
                        nxt_slot = SLOT_W'(cfg_mode_clks) - SLOT_W'(1);
                        ld       = 1'b1;
                        ld_phase = PH_MODE;
                    end else begin
                        nxt_ph = PH_DATA;
                    end
                end else begin
                    nxt_slot = slot - 1'b1;
                end
            end
            PH_MODE: if (stb) begin
                if (last) nxt_ph = PH_DATA;
                else      nxt_slot = slot - 1'b1;
            end
            PH_DATA: if (byte_done && (left == '0)) nxt_ph = PH_IDLE;
            default: nxt_ph = PH_IDLE;
        endcase
    end

    // Phase, counters, skip window, command-once memory and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            slot     <= '0;
            sidx     <= '0;
            skip_q   <= '0;
            left     <= '0;
            cmd_done <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            ph   <= nxt_ph;
            slot <= nxt_slot;
            if (accept) begin
                sidx   <= '0;
                skip_q <= send_cmd ? cfg_skip_cmd : cfg_skip_nocmd;
                left   <= req_len_m1;
                if (send_cmd && cfg_cmd_once) cmd_done <= 1'b1;
                if (bad_code) err_q <= 1'b1;
            end else begin
                if (stb && (sidx != '1)) sidx <= sidx + 1'b1;
                if (byte_done) left <= left - 1'b1;
            end
            if (!cfg_cmd_once) cmd_done <= 1'b0;
        end
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !sclk_stb |=> busy);
    // R11
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !req |=> !busy);
endmodule

// File: rtl/xip_fetch_seq.sv
// Flash fetch sequencer top: joins the phase controller, transmit shifter and
// receive assembler. Assumes one sclk_stb pulse per serial clock period from
// an external clock and select generator, and stable configuration while busy.
module xip_fetch_seq
    import xip_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int SKIP_W = 6,
    parameter int MCLK_W = 4,
    parameter int MODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [31:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    output logic              busy,
    input  logic [7:0]        cfg_cmd,
    input  logic [1:0]        cfg_cmd_w,
    input  logic [1:0]        cfg_addr_w,
    input  logic [1:0]        cfg_data_w,
    input  logic              cfg_addr4,
    input  logic [MCLK_W-1:0] cfg_mode_clks,
    input  logic [MODE_W-1:0] cfg_mode_data,
    input  logic [MODE_W-1:0] cfg_mode_oe,
    input  logic              cfg_cmd_once,
    input  logic [SKIP_W-1:0] cfg_skip_cmd,
    input  logic [SKIP_W-1:0] cfg_skip_nocmd,
    output logic              cfg_err,
    input  logic              sclk_stb,
    output logic              sel,
    output logic [3:0]        sd_out,
    output logic [3:0]        sd_oe,
    input  logic [3:0]        sd_in,
    output logic [7:0]        rd_byte,
    output logic              rd_vld
);
    logic        ld, shift, drive_en, cap, rx_start, byte_done;
    logic [1:0]  lg;
    xip_phase_e  ld_phase;
    logic [31:0] addr_q;

    // Hold the request address for the address phase
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_q <= '0;
        else if (req && !busy)      addr_q <= req_addr;
    end

    xip_seq_ctrl #(.LEN_W(LEN_W), .SKIP_W(SKIP_W), .MCLK_W(MCLK_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_len_m1(req_len_m1),
        .sclk_stb(sclk_stb), .cfg_cmd_w(cfg_cmd_w), .cfg_addr_w(cfg_addr_w),
        .cfg_data_w(cfg_data_w), .cfg_addr4(cfg_addr4),
        .cfg_mode_clks(cfg_mode_clks), .cfg_cmd_once(cfg_cmd_once),
        .cfg_skip_cmd(cfg_skip_cmd), .cfg_skip_nocmd(cfg_skip_nocmd),
        .byte_done(byte_done), .busy(busy), .sel(sel), .ld(ld),
        .ld_phase(ld_phase), .shift(shift), .lg(lg), .drive_en(drive_en),
        .cap(cap), .rx_start(rx_start), .cfg_err(cfg_err)
    );

    xip_tx_shifter #(.MODE_W(MODE_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_phase(ld_phase), .shift(shift),
        .lg(lg), .drive_en(drive_en), .cmd(cfg_cmd),
        .addr(req && !busy ? req_addr : addr_q), .addr4(cfg_addr4),
        .mode_data(cfg_mode_data), .mode_oe(cfg_mode_oe),
        .sd_out(sd_out), .sd_oe(sd_oe)
    );

    xip_rx_assembler i_rx (
        .clk(clk), .rst_n(rst_n), .start(rx_start), .cap(cap), .lg(lg),
        .sd_in(sd_in), .byte_done(byte_done), .rd_byte(rd_byte),
        .rd_vld(rd_vld)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (sd_oe == 4'h0));
    // R8
    vld_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(sel));
endmodule

// File: tb/test_xip_fetch_seq.sv
module test_xip_fetch_seq;
    localparam int LEN_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0;
    logic [31:0] req_addr = '0;
    logic [LEN_W-1:0] req_len_m1 = '0;
    logic busy, cfg_err, sel, rd_vld;
    logic [7:0] cfg_cmd = 8'h0B;
    logic [1:0] cfg_cmd_w = 0, cfg_addr_w = 0, cfg_data_w = 0;
    logic cfg_addr4 = 0, cfg_cmd_once = 0, sclk_stb = 0;
    logic [3:0] cfg_mode_clks = 0;
    logic [15:0] cfg_mode_data = 0, cfg_mode_oe = 0;
    logic [5:0] cfg_skip_cmd = 0, cfg_skip_nocmd = 0;
    logic [3:0] sd_out, sd_oe, sd_in = 0;
    logic [7:0] rd_byte;

    int checks = 0, errors = 0;
    bit exp_cmd_done = 0, exp_err = 0, finished = 0;
    int k;

    always #5 clk = ~clk;

    xip_fetch_seq #(.LEN_W(LEN_W)) i_xip_fetch_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_len_m1(req_len_m1), .busy(busy), .cfg_cmd(cfg_cmd),
        .cfg_cmd_w(cfg_cmd_w), .cfg_addr_w(cfg_addr_w), .cfg_data_w(cfg_data_w),
        .cfg_addr4(cfg_addr4), .cfg_mode_clks(cfg_mode_clks),
        .cfg_mode_data(cfg_mode_data), .cfg_mode_oe(cfg_mode_oe),
        .cfg_cmd_once(cfg_cmd_once), .cfg_skip_cmd(cfg_skip_cmd),
        .cfg_skip_nocmd(cfg_skip_nocmd), .cfg_err(cfg_err), .sclk_stb(sclk_stb),
        .sel(sel), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
        .rd_byte(rd_byte), .rd_vld(rd_vld)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int lanes(input logic [1:0] code);
        return (code == 2'd1) ? 2 : (code == 2'd2) ? 4 : 1;
    endfunction

    // Drive one serial clock strobe; caller sits at a negedge
    task automatic strobe(input logic [3:0] din);
        sd_in = din;
        sclk_stb = 1'b1;
        @(negedge clk);
        sclk_stb = 1'b0;
        k++;
    endtask

    task automatic tx_group(input logic [3:0] exp_d, input logic [3:0] exp_o,
                            input string tag);
        chk(sd_oe == exp_o, {tag, " oe"}, {28'h0, sd_oe}, {28'h0, exp_o});
        chk((sd_out & exp_o) == (exp_d & exp_o), {tag, " data"},
            {28'h0, sd_out & exp_o}, {28'h0, exp_d & exp_o});
        strobe(4'($urandom));
        chk(rd_vld == 1'b0, {tag, " no vld"}, {31'h0, rd_vld}, 32'h0);
        @(negedge clk);
    endtask

    task automatic run_txn(input logic [31:0] a, input logic [LEN_W-1:0] lm1,
                           input bit hold_req);
        bit send;
        int L, abits, nb, bc, skip;
        logic [31:0] av;
        logic [7:0] acc;
        logic [3:0] m, din, grp;
        send = !(cfg_cmd_once && exp_cmd_done);
        if (cfg_cmd_w == 3 || cfg_addr_w == 3 || cfg_data_w == 3) exp_err = 1;
        @(negedge clk);
        chk(busy == 1'b0, "R2 idle before request", {31'h0, busy}, 32'h0);
        req = 1'b1; req_addr = a; req_len_m1 = lm1;
        @(negedge clk);
        if (!hold_req) req = 1'b0;
        req_addr = ~a;
        chk(sel && busy, "R2 sel/busy after accept", {30'h0, sel, busy}, 32'h3);
        if (send && cfg_cmd_once) exp_cmd_done = 1;
        if (!cfg_cmd_once) exp_cmd_done = 0;
        k = 0;
        if (send) begin
            L = lanes(cfg_cmd_w); m = 4'((1 << L) - 1);
            for (int s = 0; s < 8 / L; s++)
                tx_group(4'((cfg_cmd >> (8 - (s + 1) * L)) & m), m, "R3 command");
        end
        L = lanes(cfg_addr_w); m = 4'((1 << L) - 1);
        abits = cfg_addr4 ? 32 : 24;
        av = cfg_addr4 ? a : {8'h00, a[23:0]};
        for (int s = 0; s < abits / L; s++)
            tx_group(4'((av >> (abits - (s + 1) * L)) & m), m, "R4 address");
        for (int s = 0; s < int'(cfg_mode_clks); s++) begin
            if ((s + 1) * L <= 16)
                tx_group(4'((cfg_mode_data >> (16 - (s + 1) * L)) & m),
                         4'((cfg_mode_oe >> (16 - (s + 1) * L)) & m), "R5 mode");
            else
                tx_group(4'h0, 4'h0, "R5 mode past pattern");
        end
        req = 1'b0;
        L = lanes(cfg_data_w);
        skip = send ? int'(cfg_skip_cmd) : int'(cfg_skip_nocmd);
        nb = 0; bc = 0; acc = 0;
        while (nb <= int'(lm1)) begin
            bit got;
            chk(sd_oe == 4'h0, "R6 data phase oe", {28'h0, sd_oe}, 32'h0);
            din = 4'($urandom);
            got = 0;
            if (k >= skip) begin
                grp = (L == 1) ? {3'b0, din[1]} : (L == 2) ? {2'b0, din[1:0]} : din;
                acc = 8'((acc << L) | {4'h0, grp});
                bc += L;
                if (bc == 8) begin got = 1; bc = 0; nb++; end
            end
            strobe(din);
            chk(rd_vld == got, "R7 valid timing/skip", {31'h0, rd_vld}, {31'h0, got});
            if (got) begin
                chk(rd_byte == acc, "R6 byte value", {24'h0, rd_byte}, {24'h0, acc});
                acc = 0;
            end
            if (nb <= int'(lm1)) begin
                chk(sel == 1'b1, "R8 sel held", {31'h0, sel}, 32'h1);
                @(negedge clk);
            end
        end
        chk(!sel && !busy, "R8 end after last byte", {30'h0, sel, busy}, 32'h0);
        chk(cfg_err == exp_err, "R10 error flag", {31'h0, cfg_err}, {31'h0, exp_err});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_cmd_done = 0; exp_err = 0;
        chk(!sel && !busy && !rd_vld && !cfg_err && sd_oe == 0,
            "R1 reset state", {27'h0, sel, busy, rd_vld, cfg_err, |sd_oe}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        @(negedge clk);
        do_reset();
        // R11: strobes while idle do nothing
        for (int i = 0; i < 4; i++) begin
            strobe(4'hF);
            chk(!busy && !sel && sd_oe == 0 && !rd_vld, "R11 idle strobe",
                {29'h0, busy, sel, rd_vld}, 32'h0);
        end
        // Directed: single lines, 3-byte address, no mode
        run_txn(32'hA1B2C3D4, 0, 0);
        // Quad everywhere, 4-byte address, long mode, request held (R2)
        cfg_cmd_w = 2; cfg_addr_w = 2; cfg_data_w = 2; cfg_addr4 = 1;
        cfg_mode_clks = 15; cfg_mode_data = 16'hA5F0; cfg_mode_oe = 16'hFF0F;
        cfg_skip_cmd = 63;
        run_txn(32'h12345678, 3, 1);
        // R9: command-once sequence
        cfg_cmd_once = 1; cfg_cmd_w = 1; cfg_addr_w = 1; cfg_data_w = 1;
        cfg_addr4 = 0; cfg_mode_clks = 2; cfg_skip_cmd = 5; cfg_skip_nocmd = 20;
        run_txn(32'h00FFEE11, 1, 0);
        run_txn(32'h00445566, 2, 0);
        run_txn(32'h00778899, 0, 0);
        cfg_cmd_once = 0;
        @(negedge clk);
        run_txn(32'h00123456, 1, 0);
        // Random mix
        for (int t = 0; t < 40; t++) begin
            cfg_cmd = 8'($urandom);
            cfg_cmd_w = 2'($urandom_range(0, 2));
            cfg_addr_w = 2'($urandom_range(0, 2));
            cfg_data_w = 2'($urandom_range(0, 2));
            cfg_addr4 = 1'($urandom);
            cfg_mode_clks = 4'($urandom);
            cfg_mode_data = 16'($urandom);
            cfg_mode_oe = 16'($urandom);
            cfg_skip_cmd = 6'($urandom);
            cfg_skip_nocmd = 6'($urandom);
            if (t % 8 == 0) cfg_cmd_once = ~cfg_cmd_once;
            @(negedge clk);
            run_txn($urandom, LEN_W'($urandom), 1'($urandom));
        end
        // R10: invalid data width code runs single-line and sets the flag
        cfg_cmd_once = 0; @(negedge clk);
        cfg_cmd_w = 0; cfg_addr_w = 2; cfg_data_w = 3; cfg_mode_clks = 0;
        run_txn(32'h00C0FFEE, 2, 0);
        cfg_data_w = 0;
        run_txn(32'h00BEEF00, 0, 0);
        do_reset();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule